// File: doc/BRIEF.md
# Segmented Physical Address Generator

This block turns a 16-bit segment base and a 16-bit offset into a 20-bit physical address, the way a processor bus interface unit does. The segment is shifted left by four bit positions and the offset is added. A sum that passes the top of the 20-bit space wraps back to zero.

It keeps four 16-bit segment registers: code, data, stack and extra. A write port loads them. A request carries an offset and a code for the pointer that supplied it. From that code the block picks the segment that normally pairs with that pointer. For data references, a qualified override can name a different segment instead.

The address is registered. It appears one cycle after the request, together with a valid flag. Reset loads the code segment with FFFFh, so that an instruction-pointer offset of zero gives the first fetch address FFFF0h.

Top module: `seg_addr_unit`

## Requirements
- R1: The physical address is the selected 16-bit segment with four zero bits appended below it, plus the zero-extended 16-bit offset. Segment A4FBh with offset 4872h gives A9822h.
- R2: Sums of 100000h or more wrap modulo 2^20, and the carry out of bit 19 is dropped. For example, FFFFh:0010h gives 00000h.
- R3: The source code `req_src` picks the default segment:
  - 0, the instruction pointer, uses code.
  - 1, the source index, uses data.
  - 2, the destination index, uses extra.
  - 3, the stack pointer, uses stack.
  - 4, the base pointer, uses stack.
  - Codes 5 to 7 are general data references and use data.
- R4: When `ovr_en` is 1, `ovr_seg` replaces the default segment for source codes 1, 2, 4, 5, 6 and 7. It is ignored for codes 0 and 3, and it is ignored whenever `ovr_en` is 0.
- R5: Segment select encoding, used by both `ovr_seg` and `seg_wr_sel`:
  - 0 is extra.
  - 1 is code.
  - 2 is stack.
  - 3 is data.
- R6: A segment write with `seg_wr_en` high takes effect at the next rising clock edge. A request in the same cycle as a write uses the old value.
- R7: After reset, the code segment is FFFFh and the other segments are 0000h. `addr_out` reads FFFF0h and `addr_valid` is 0.
- R8: `addr_valid` in each cycle equals `req` from the previous cycle. The address for a request appears on `addr_out` one cycle after that request.
- R9: When `req` is low, `addr_out` keeps its last value. This holds even if a segment register is written in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| seg_wr_en | input | 1 | Load the segment register named by seg_wr_sel |
| seg_wr_sel | input | 2 | Segment register to load (R5 encoding) |
| seg_wr_data | input | 16 | New segment value |
| req | input | 1 | Address request strobe |
| req_src | input | 3 | Pointer source of the offset (R3 encoding) |
| req_off | input | 16 | Offset value |
| ovr_en | input | 1 | Segment override is valid |
| ovr_seg | input | 2 | Override segment (R5 encoding) |
| addr_out | output | 20 | Registered physical address |
| addr_valid | output | 1 | addr_out holds the result of the previous cycle's request |

## Verification
The bench builds the block with its default parameters: 16-bit segments and offsets, a four-bit shift and a code-segment reset value of FFFFh. This makes the reset fetch vector FFFF0h and its wrapped neighbour directly observable. Segments loaded near the top of the space then drive several sums past bit 19.

With these widths, every pairing of source code and override can be written as a literal expected address. This includes the ignored overrides on fetch and stack-pointer references. A write and a request issued in the same cycle show whether the old or the new segment was used.

// File: rtl/seg_addr_unit.sv
module seg_addr_unit #(
  parameter int SEG_W = 16,
  parameter int OFF_W = 16,
  parameter int SHIFT = 4,
  parameter logic [SEG_W-1:0] RESET_CODE = '1,
  localparam int ADDR_W = SEG_W + SHIFT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              seg_wr_en,
  input  logic [1:0]        seg_wr_sel,
  input  logic [SEG_W-1:0]  seg_wr_data,
  input  logic              req,
  input  logic [2:0]        req_src,
  input  logic [OFF_W-1:0]  req_off,
  input  logic              ovr_en,
  input  logic [1:0]        ovr_seg,
  output logic [ADDR_W-1:0] addr_out,
  output logic              addr_valid
);
  localparam logic [1:0] SEL_EXTRA = 2'd0;
  localparam logic [1:0] SEL_CODE  = 2'd1;
  localparam logic [1:0] SEL_STACK = 2'd2;
  localparam logic [1:0] SEL_DATA  = 2'd3;

  localparam logic [2:0] SRC_IP = 3'd0;
  localparam logic [2:0] SRC_SI = 3'd1;
  localparam logic [2:0] SRC_DI = 3'd2;
  localparam logic [2:0] SRC_SP = 3'd3;
  localparam logic [2:0] SRC_BP = 3'd4;

  logic [SEG_W-1:0]  seg_q [4];
  logic [1:0]        dflt_sel;
  logic [1:0]        use_sel;
  logic              ovr_ok;
  logic [ADDR_W-1:0] sum;

  always_comb begin
    case (req_src)
      SRC_IP:         dflt_sel = SEL_CODE;
      SRC_SI:         dflt_sel = SEL_DATA;
      SRC_DI:         dflt_sel = SEL_EXTRA;
      SRC_SP, SRC_BP: dflt_sel = SEL_STACK;
      default:        dflt_sel = SEL_DATA;
    endcase
  end

  assign ovr_ok  = ovr_en && (req_src != SRC_IP) && (req_src != SRC_SP);
  assign use_sel = ovr_ok ? ovr_seg : dflt_sel;
  assign sum     = {seg_q[use_sel], {SHIFT{1'b0}}} + ADDR_W'(req_off);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++)
        seg_q[i] <= (2'(i) == SEL_CODE) ? RESET_CODE : '0;
    end else if (seg_wr_en) begin
      seg_q[seg_wr_sel] <= seg_wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_out   <= {RESET_CODE, {SHIFT{1'b0}}};
      addr_valid <= 1'b0;
    end else begin
      addr_valid <= req;
      if (req) addr_out <= sum;
    end
  end
endmodule

// File: rtl/seg_addr_unit_chk.sv
module seg_addr_unit_chk #(
  parameter int SEG_W = 16,
  parameter int OFF_W = 16,
  parameter int SHIFT = 4,
  localparam int ADDR_W = SEG_W + SHIFT
) (
  input logic              clk,
  input logic              rst_n,
  input logic              seg_wr_en,
  input logic [1:0]        seg_wr_sel,
  input logic [SEG_W-1:0]  seg_wr_data,
  input logic              req,
  input logic [2:0]        req_src,
  input logic [OFF_W-1:0]  req_off,
  input logic [SEG_W-1:0]  seg [4],
  input logic [ADDR_W-1:0] addr_out,
  input logic              addr_valid
);
  AST_VALID_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid == $past(req)); // R8

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> $stable(addr_out)); // R9

  AST_FETCH_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (req && req_src == 3'd0) |=>
      addr_out == ({$past(seg[1]), {SHIFT{1'b0}}} + ADDR_W'($past(req_off)))); // R4

  AST_STACK_PTR: assert property (@(posedge clk) disable iff (!rst_n)
    (req && req_src == 3'd3) |=>
      addr_out == ({$past(seg[2]), {SHIFT{1'b0}}} + ADDR_W'($past(req_off)))); // R3

  AST_SEG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    seg_wr_en |=> seg[$past(seg_wr_sel)] == $past(seg_wr_data)); // R6
endmodule

bind seg_addr_unit seg_addr_unit_chk #(.SEG_W(SEG_W), .OFF_W(OFF_W), .SHIFT(SHIFT)) chk_i (
  .clk(clk), .rst_n(rst_n), .seg_wr_en(seg_wr_en), .seg_wr_sel(seg_wr_sel),
  .seg_wr_data(seg_wr_data), .req(req), .req_src(req_src), .req_off(req_off),
  .seg(seg_q), .addr_out(addr_out), .addr_valid(addr_valid));

// File: tb/seg_addr_unit_tb_top.sv
module seg_addr_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 13;

  // {src[3], ovr_en, ovr_seg[2], offset[16], expected[20]}
  // segments: code=A4FB, data=1234, stack=F000, extra=FFFF
  localparam logic [41:0] VEC [NVEC] = '{
    {3'd0, 1'b0, 2'd0, 16'h4872, 20'hA9822},  // R1 example
    {3'd1, 1'b0, 2'd0, 16'h0010, 20'h12350},  // R3 SI->data
    {3'd2, 1'b0, 2'd0, 16'h0001, 20'hFFFF1},  // R3 DI->extra
    {3'd3, 1'b0, 2'd0, 16'hFFFE, 20'hFFFFE},  // R3 SP->stack
    {3'd4, 1'b0, 2'd0, 16'h0002, 20'hF0002},  // R3 BP->stack
    {3'd2, 1'b0, 2'd0, 16'h0020, 20'h00010},  // R2 wrap
    {3'd1, 1'b1, 2'd1, 16'h0000, 20'hA4FB0},  // R4 SI ovr code
    {3'd2, 1'b1, 2'd2, 16'h0003, 20'hF0003},  // R4 DI ovr stack
    {3'd4, 1'b1, 2'd3, 16'h0005, 20'h12345},  // R4 BP ovr data
    {3'd0, 1'b1, 2'd3, 16'h0000, 20'hA4FB0},  // R4 IP ignores ovr
    {3'd3, 1'b1, 2'd0, 16'h0004, 20'hF0004},  // R4 SP ignores ovr
    {3'd1, 1'b0, 2'd1, 16'h0007, 20'h12347},  // R4 ovr_en low
    {3'd5, 1'b0, 2'd0, 16'h0008, 20'h12348}   // R3 code 5 -> data
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        seg_wr_en = 1'b0;
  logic [1:0]  seg_wr_sel = '0;
  logic [15:0] seg_wr_data = '0;
  logic        req = 1'b0;
  logic [2:0]  req_src = '0;
  logic [15:0] req_off = '0;
  logic        ovr_en = 1'b0;
  logic [1:0]  ovr_seg = '0;
  logic [19:0] addr_out;
  logic        addr_valid;

  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  seg_addr_unit dut_i (
    .clk(clk), .rst_n(rst_n), .seg_wr_en(seg_wr_en), .seg_wr_sel(seg_wr_sel),
    .seg_wr_data(seg_wr_data), .req(req), .req_src(req_src), .req_off(req_off),
    .ovr_en(ovr_en), .ovr_seg(ovr_seg), .addr_out(addr_out), .addr_valid(addr_valid));

  task automatic check(input string tag, input logic [19:0] act, input logic [19:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: got %05h expected %05h", tag, act, exp);
    end
  endtask

  task automatic seg_write(input logic [1:0] sel, input logic [15:0] val);
    @(negedge clk);
    seg_wr_en = 1'b1; seg_wr_sel = sel; seg_wr_data = val;
    @(negedge clk);
    seg_wr_en = 1'b0;
  endtask

  task automatic issue(input logic [2:0] src, input logic oe, input logic [1:0] os,
                       input logic [15:0] off);
    @(negedge clk);
    req = 1'b1; req_src = src; ovr_en = oe; ovr_seg = os; req_off = off;
    @(negedge clk);
    req = 1'b0; ovr_en = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R7 reset addr_out", addr_out, 20'hFFFF0);
    check("R7 reset addr_valid", {19'b0, addr_valid}, 20'h0);
    rst_n = 1'b1;

    issue(3'd0, 1'b0, 2'd0, 16'h0000);
    check("R7 first fetch", addr_out, 20'hFFFF0);
    check("R8 valid after req", {19'b0, addr_valid}, 20'h1);
    issue(3'd0, 1'b0, 2'd0, 16'h0010);
    check("R2 wrap from reset code seg", addr_out, 20'h00000);
    issue(3'd1, 1'b0, 2'd0, 16'h0005);
    check("R7 data seg reset zero", addr_out, 20'h00005);

    seg_write(2'd1, 16'hA4FB);
    seg_write(2'd3, 16'h1234);
    seg_write(2'd2, 16'hF000);
    seg_write(2'd0, 16'hFFFF);

    for (int i = 0; i < NVEC; i++) begin
      issue(VEC[i][41:39], VEC[i][38], VEC[i][37:36], VEC[i][35:20]);
      check($sformatf("R1/R3/R4/R5 vector %0d", i), addr_out, VEC[i][19:0]);
      check($sformatf("R8 vector %0d valid", i), {19'b0, addr_valid}, 20'h1);
    end

    @(negedge clk);
    req = 1'b1; req_src = 3'd0; req_off = 16'h0001;
    seg_wr_en = 1'b1; seg_wr_sel = 2'd1; seg_wr_data = 16'h2000;
    @(negedge clk);
    req = 1'b0; seg_wr_en = 1'b0;
    check("R6 same-cycle write uses old seg", addr_out, 20'hA4FB1);
    issue(3'd0, 1'b0, 2'd0, 16'h0001);
    check("R6 new seg after write", addr_out, 20'h20001);

    @(negedge clk);
    seg_wr_en = 1'b1; seg_wr_sel = 2'd1; seg_wr_data = 16'h3000;
    @(negedge clk);
    seg_wr_en = 1'b0;
    check("R8 valid low without req", {19'b0, addr_valid}, 20'h0);
    check("R9 addr held without req", addr_out, 20'h20001);
    @(negedge clk);
    check("R9 addr still held", addr_out, 20'h20001);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule